// File: doc/BRIEF.md
# Microprogram Multiply-Accumulate Step Core

This block is the arithmetic heart of an audio effects sequencer. Each clock edge ends one microprogram step. In each step the block picks a 24-bit X operand and a 13-bit Y operand and forms their signed product. It scales the product down to 26 bits and adds an optional B term. The B term can be inverted, gated off, or taken from the previous result. The sum is stored in a result register.

The result register from the previous step feeds a four-mode output shifter. Two of its modes clamp the value, and two wrap it to 24 bits. The shifter output drives several writebacks:
- a 128-entry temporary ring, addressed relative to a moving base;
- a fraction register, which can serve as the next Y operand;
- an address register;
- an effect output strobe, with a slot number and 16 data bits.

A Y register can capture the upper 20 bits of the input bus, so a later step can use it as a multiplier. The instruction fields arrive already decoded as input pins. The ring base counter, external memory and mixing sources sit outside the block.

Top module: `fx_mac_core`

## Requirements
- R1: After reset, the result, fraction, address and Y registers are zero, the effect strobe is low, and every ring entry reads as zero.
- R2: X is `in_bus` when `x_sel`=1. Otherwise X is the ring entry at index (`ring_base` + `rd_ofs`) mod 128, treated as signed 24-bit.
- R3: `y_sel` picks Y as follows: 0 is the fraction register (signed 13-bit); 1 is `coef[15:3]` (signed); 2 is Y register bits 19:7 (signed); 3 is Y register bits 11:0 with a zero bit on top.
- R4: The signed X*Y product is arithmetically shifted right by 10 and truncated to 26 bits. Product plus B, truncated to 26 bits, is stored in `acc_out` at the end of the step.
- R5: B is the previous `acc_out` when `b_sel`=1, or the read ring entry times 4 when `b_sel`=0. `zero_b`=1 forces B to 0. `neg_b`=1 subtracts B instead of adding it.
- R6: The shifter input is `acc_out` as held during the step. Modes 0 and 1 shift it right by 2 and by 1 respectively, then clamp to the range -2^19 .. 2^19-1.
- R7: Mode 2 shifts right by 1 and keeps the low 24 bits. Mode 3 passes the low 24 bits unscaled.
- R8: `efx_we`=1 makes `efx_vld` high for the next cycle. In that cycle `efx_idx` equals `efx_slot` and `efx_data` equals shifter bits 19:4. With `efx_we`=0, `efx_vld` is low.
- R9: `temp_we`=1 stores the 24-bit shifter value at (`ring_base` + `wr_ofs`) mod 128. A read of the same index in the same step returns the value held before that write.
- R10: With `frac_ld`=1 the fraction register loads shifter bits 23:11 in mode 3, and {0, shifter bits 11:0} in the other modes. Otherwise it holds its value.
- R11: With `addr_ld`=1 the address register loads shifter bits 23:16 sign-extended to 12 bits in mode 3, and shifter bits 23:12 in the other modes. Otherwise it holds its value.
- R12: With `y_ld`=1 the Y register loads `in_bus[23:4]`. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock; every rising edge ends a step |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_bus | input | 24 | Signed input sample bus |
| coef | input | 16 | Step coefficient; upper 13 bits used |
| ring_base | input | 7 | Moving base of the temporary ring |
| x_sel | input | 1 | 1: X from in_bus, 0: X from ring |
| rd_ofs | input | 7 | Ring read offset |
| y_sel | input | 2 | Y operand source |
| b_sel | input | 1 | 1: B from previous result, 0: B from ring*4 |
| neg_b | input | 1 | Subtract B |
| zero_b | input | 1 | Gate B to zero |
| shift_mode | input | 2 | Output shifter mode |
| temp_we | input | 1 | Write shifter value into ring |
| wr_ofs | input | 7 | Ring write offset |
| efx_we | input | 1 | Emit effect output |
| efx_slot | input | 4 | Effect output slot |
| frac_ld | input | 1 | Load fraction register |
| addr_ld | input | 1 | Load address register |
| y_ld | input | 1 | Load Y register |
| acc_out | output | 26 | Result register |
| frac_out | output | 13 | Fraction register |
| addr_out | output | 12 | Address register |
| yreg_out | output | 20 | Y register |
| efx_vld | output | 1 | Effect output strobe |
| efx_idx | output | 4 | Effect output slot |
| efx_data | output | 16 | Effect output value |

## Verification
Two things can coincide in one step: a ring read and a ring write to the same index. The same happens when the fraction register is loaded while it also serves as the Y operand. The bench provokes the first case by giving `rd_ofs` and `wr_ofs` the same value with `temp_we` set. It provokes the second by combining `frac_ld` with `y_sel`=0. A step-level reference model judges both by requiring that the product, B term and writebacks use only values from before the edge. Random steps add many further coincidences of result feedback, saturation and ring aliasing.

// File: rtl/fx_mac_pkg.sv
package fx_mac_pkg;

    localparam int unsigned DATA_W  = 24;
    localparam int unsigned ACC_W   = DATA_W + 2;
    localparam int unsigned MULY_W  = 13;
    localparam int unsigned COEF_W  = 16;
    localparam int unsigned FRAC_W  = 13;
    localparam int unsigned ADRR_W  = 12;
    localparam int unsigned YREG_W  = 20;
    localparam int unsigned EFX_W   = 16;
    localparam int unsigned SLOT_W  = 4;

    typedef enum logic [1:0] {
        SH_SAT_DIV4 = 2'd0,
        SH_SAT_DIV2 = 2'd1,
        SH_WRP_DIV2 = 2'd2,
        SH_WRP_UNIT = 2'd3
    } shift_mode_e;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [FRAC_W-1:0] frac;
        logic [ADRR_W-1:0] adr;
        logic [YREG_W-1:0] yreg;
        logic              efx_vld;
        logic [SLOT_W-1:0] efx_slot;
        logic [EFX_W-1:0]  efx_dat;
    } core_state_t;

endpackage

// File: rtl/fx_temp_ring.sv
module fx_temp_ring #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned DW    = 24,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] base,
    input  logic [IW-1:0] rd_ofs,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_ofs,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];
    logic [IW-1:0] rd_idx;
    logic [IW-1:0] wr_idx;

    always_comb begin
        rd_idx  = base + rd_ofs;
        wr_idx  = base + wr_ofs;
        rd_data = mem_q[rd_idx];
        mem_d   = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/fx_mac_path.sv
module fx_mac_path #(
    parameter int unsigned DW     = 24,
    parameter int unsigned YW     = 13,
    parameter int unsigned CW     = 16,
    parameter int unsigned FW     = 13,
    parameter int unsigned YRW    = 20,
    parameter int unsigned PSHIFT = 10,
    localparam int unsigned AW    = DW + 2,
    localparam int unsigned PW    = DW + YW
) (
    input  logic          x_sel,
    input  logic [1:0]    y_sel,
    input  logic [DW-1:0] in_bus,
    input  logic [DW-1:0] tmp_rd,
    input  logic [CW-1:0] coef,
    input  logic [FW-1:0] frac_q,
    input  logic [YRW-1:0] yreg_q,
    input  logic [AW-1:0] acc_q,
    input  logic          b_sel,
    input  logic          neg_b,
    input  logic          zero_b,
    output logic [AW-1:0] prod_o,
    output logic [AW-1:0] sum_o
);
    logic signed [DW-1:0] x_op;
    logic signed [YW-1:0] y_op;
    logic signed [PW-1:0] p_full;
    logic signed [PW-1:0] p_scaled;
    logic [AW-1:0]        b_raw;
    logic [AW-1:0]        b_gate;
    logic [AW-1:0]        b_eff;

    always_comb begin
        x_op = x_sel ? in_bus : tmp_rd;
        unique case (y_sel)
            2'd0:    y_op = frac_q[YW-1:0];
            2'd1:    y_op = coef[CW-1:CW-YW];
            2'd2:    y_op = yreg_q[YRW-1:YRW-YW];
            default: y_op = {1'b0, yreg_q[YW-2:0]};
        endcase
        p_full   = x_op * y_op;
        p_scaled = p_full >>> PSHIFT;
        prod_o   = p_scaled[AW-1:0];

        b_raw  = b_sel ? acc_q : {tmp_rd, 2'b00};
        b_gate = zero_b ? '0 : b_raw;
        b_eff  = neg_b ? (~b_gate + 1'b1) : b_gate;
        sum_o  = prod_o + b_eff;
    end
endmodule

// File: rtl/fx_out_shift.sv
module fx_out_shift
    import fx_mac_pkg::*;
#(
    parameter int unsigned DW    = 24,
    parameter int unsigned SATB  = 19,
    localparam int unsigned AW   = DW + 2
) (
    input  logic [AW-1:0] acc_q,
    input  logic [1:0]    mode,
    output logic [DW-1:0] sh_o
);
    localparam logic signed [AW-1:0] SAT_HI = AW'((1 << SATB) - 1);
    localparam logic signed [AW-1:0] SAT_LO = -AW'(1 << SATB);

    logic signed [AW-1:0] half_v;
    logic signed [AW-1:0] quart_v;
    logic signed [AW-1:0] sel_v;
    shift_mode_e          mode_e;

    always_comb begin
        mode_e  = shift_mode_e'(mode);
        half_v  = $signed(acc_q) >>> 1;
        quart_v = $signed(acc_q) >>> 2;
        sel_v   = (mode_e == SH_SAT_DIV4) ? quart_v : half_v;
        unique case (mode_e)
            SH_SAT_DIV4, SH_SAT_DIV2: begin
                if (sel_v > SAT_HI)      sh_o = SAT_HI[DW-1:0];
                else if (sel_v < SAT_LO) sh_o = SAT_LO[DW-1:0];
                else                     sh_o = sel_v[DW-1:0];
            end
            SH_WRP_DIV2: sh_o = half_v[DW-1:0];
            default:     sh_o = acc_q[DW-1:0];
        endcase
    end
endmodule

// File: rtl/fx_mac_core.sv
module fx_mac_core
    import fx_mac_pkg::*;
#(
    parameter int unsigned RING_DEPTH = 128,
    parameter int unsigned PSHIFT     = 10,
    parameter int unsigned SATB       = 19,
    parameter int unsigned EFX_LO     = 4,
    parameter int unsigned ADR_LO     = 16,
    localparam int unsigned RIW       = $clog2(RING_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  in_bus,
    input  logic [COEF_W-1:0]  coef,
    input  logic [RIW-1:0]     ring_base,
    input  logic               x_sel,
    input  logic [RIW-1:0]     rd_ofs,
    input  logic [1:0]         y_sel,
    input  logic               b_sel,
    input  logic               neg_b,
    input  logic               zero_b,
    input  logic [1:0]         shift_mode,
    input  logic               temp_we,
    input  logic [RIW-1:0]     wr_ofs,
    input  logic               efx_we,
    input  logic [SLOT_W-1:0]  efx_slot,
    input  logic               frac_ld,
    input  logic               addr_ld,
    input  logic               y_ld,
    output logic [ACC_W-1:0]   acc_out,
    output logic [FRAC_W-1:0]  frac_out,
    output logic [ADRR_W-1:0]  addr_out,
    output logic [YREG_W-1:0]  yreg_out,
    output logic               efx_vld,
    output logic [SLOT_W-1:0]  efx_idx,
    output logic [EFX_W-1:0]   efx_data
);
    localparam int unsigned ADR_SL = DATA_W - ADR_LO;

    core_state_t       st_q;
    core_state_t       st_d;
    logic [DATA_W-1:0] tmp_rd_w;
    logic [DATA_W-1:0] sh_w;
    logic [ACC_W-1:0]  prod_w;
    logic [ACC_W-1:0]  sum_w;

    fx_temp_ring #(.DEPTH(RING_DEPTH), .DW(DATA_W)) i_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (ring_base),
        .rd_ofs  (rd_ofs),
        .rd_data (tmp_rd_w),
        .wr_en   (temp_we),
        .wr_ofs  (wr_ofs),
        .wr_data (sh_w)
    );

    fx_mac_path #(
        .DW(DATA_W), .YW(MULY_W), .CW(COEF_W), .FW(FRAC_W),
        .YRW(YREG_W), .PSHIFT(PSHIFT)
    ) i_path (
        .x_sel  (x_sel),
        .y_sel  (y_sel),
        .in_bus (in_bus),
        .tmp_rd (tmp_rd_w),
        .coef   (coef),
        .frac_q (st_q.frac),
        .yreg_q (st_q.yreg),
        .acc_q  (st_q.acc),
        .b_sel  (b_sel),
        .neg_b  (neg_b),
        .zero_b (zero_b),
        .prod_o (prod_w),
        .sum_o  (sum_w)
    );

    fx_out_shift #(.DW(DATA_W), .SATB(SATB)) i_shift (
        .acc_q (st_q.acc),
        .mode  (shift_mode),
        .sh_o  (sh_w)
    );

    always_comb begin
        st_d         = st_q;
        st_d.acc     = sum_w;
        st_d.efx_vld = efx_we;
        if (efx_we) begin
            st_d.efx_slot = efx_slot;
            st_d.efx_dat  = sh_w[EFX_LO+EFX_W-1:EFX_LO];
        end
        if (frac_ld) begin
            st_d.frac = (shift_mode == SH_WRP_UNIT) ? sh_w[DATA_W-1:DATA_W-FRAC_W]
                                                    : {1'b0, sh_w[FRAC_W-2:0]};
        end
        if (addr_ld) begin
            st_d.adr = (shift_mode == SH_WRP_UNIT)
                     ? {{(ADRR_W-ADR_SL){sh_w[DATA_W-1]}}, sh_w[DATA_W-1:ADR_LO]}
                     : sh_w[DATA_W-1:DATA_W-ADRR_W];
        end
        if (y_ld) begin
            st_d.yreg = in_bus[DATA_W-1:DATA_W-YREG_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_out  = st_q.acc;
    assign frac_out = st_q.frac;
    assign addr_out = st_q.adr;
    assign yreg_out = st_q.yreg;
    assign efx_vld  = st_q.efx_vld;
    assign efx_idx  = st_q.efx_slot;
    assign efx_data = st_q.efx_dat;

    assert_sat_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_mode[1] == 1'b0) |->
        ($signed(sh_w) <= $signed(DATA_W'((1 << SATB) - 1)) &&
         $signed(sh_w) >= -$signed(DATA_W'(1 << SATB))));

    assert_zero_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        zero_b |=> (acc_out == $past(prod_w)));

    assert_efx_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        efx_we |=> (efx_vld && efx_idx == $past(efx_slot) &&
                    efx_data == $past(sh_w[EFX_LO+EFX_W-1:EFX_LO])));

    assert_efx_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !efx_we |=> !efx_vld);

    assert_frac_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frac_ld |=> $stable(frac_out));

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ld |=> $stable(addr_out));

    assert_y_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        y_ld |=> (yreg_out == $past(in_bus[DATA_W-1:DATA_W-YREG_W])));

    assert_y_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !y_ld |=> $stable(yreg_out));
endmodule

// File: tb/test_fx_mac_core.sv
`timescale 1ns/1ps
module test_fx_mac_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] in_bus = '0;
    logic [15:0] coef = '0;
    logic [6:0]  ring_base = '0;
    logic        x_sel = 1'b0;
    logic [6:0]  rd_ofs = '0;
    logic [1:0]  y_sel = '0;
    logic        b_sel = 1'b0, neg_b = 1'b0, zero_b = 1'b0;
    logic [1:0]  shift_mode = '0;
    logic        temp_we = 1'b0;
    logic [6:0]  wr_ofs = '0;
    logic        efx_we = 1'b0;
    logic [3:0]  efx_slot = '0;
    logic        frac_ld = 1'b0, addr_ld = 1'b0, y_ld = 1'b0;
    logic [25:0] acc_out;
    logic [12:0] frac_out;
    logic [11:0] addr_out;
    logic [19:0] yreg_out;
    logic        efx_vld;
    logic [3:0]  efx_idx;
    logic [15:0] efx_data;

    always #4 clk = ~clk;

    fx_mac_core i_fx_mac_core (
        .clk(clk), .rst_n(rst_n), .in_bus(in_bus), .coef(coef),
        .ring_base(ring_base), .x_sel(x_sel), .rd_ofs(rd_ofs), .y_sel(y_sel),
        .b_sel(b_sel), .neg_b(neg_b), .zero_b(zero_b), .shift_mode(shift_mode),
        .temp_we(temp_we), .wr_ofs(wr_ofs), .efx_we(efx_we), .efx_slot(efx_slot),
        .frac_ld(frac_ld), .addr_ld(addr_ld), .y_ld(y_ld),
        .acc_out(acc_out), .frac_out(frac_out), .addr_out(addr_out),
        .yreg_out(yreg_out), .efx_vld(efx_vld), .efx_idx(efx_idx),
        .efx_data(efx_data)
    );

    typedef struct packed {
        logic [25:0] acc;
        logic [12:0] frac;
        logic [11:0] adr;
        logic [19:0] yreg;
        logic        vld;
        logic [3:0]  slot;
        logic [15:0] dat;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    logic [23:0] m_tmp [128];
    logic [25:0] m_acc = '0;
    logic [12:0] m_frac = '0;
    logic [11:0] m_adr = '0;
    logic [19:0] m_y = '0;

    function automatic longint sx(input longint v, input int w);
        longint t;
        t = v <<< (64 - w);
        return t >>> (64 - w);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic do_step(input string tag, input logic [23:0] i_in, input logic [15:0] i_coef,
                           input logic [6:0] i_base, input logic i_xs, input logic [6:0] i_rd,
                           input logic [1:0] i_ys, input logic i_bs, input logic i_nb,
                           input logic i_zb, input logic [1:0] i_sm, input logic i_twe,
                           input logic [6:0] i_wr, input logic i_ewe, input logic [3:0] i_slot,
                           input logic i_fld, input logic i_ald, input logic i_yld);
        longint tmpv, xv, yv, pv, bv, sv, av, shv;
        logic [23:0] sh24;
        exp_t e;
        @(negedge clk);
        in_bus = i_in; coef = i_coef; ring_base = i_base; x_sel = i_xs; rd_ofs = i_rd;
        y_sel = i_ys; b_sel = i_bs; neg_b = i_nb; zero_b = i_zb; shift_mode = i_sm;
        temp_we = i_twe; wr_ofs = i_wr; efx_we = i_ewe; efx_slot = i_slot;
        frac_ld = i_fld; addr_ld = i_ald; y_ld = i_yld;
        tmpv = sx(longint'(m_tmp[7'(i_base + i_rd)]), 24);
        xv = i_xs ? sx(longint'(i_in), 24) : tmpv;
        case (i_ys)
            2'd0: yv = sx(longint'(m_frac), 13);
            2'd1: yv = sx(longint'(i_coef >> 3), 13);
            2'd2: yv = sx(longint'(m_y >> 7), 13);
            default: yv = longint'(m_y & 20'hFFF);
        endcase
        pv = sx((xv * yv) >>> 10, 26);
        bv = i_bs ? sx(longint'(m_acc), 26) : tmpv * 4;
        if (i_zb) bv = 0;
        if (i_nb) bv = -bv;
        sv = sx(pv + bv, 26);
        av = sx(longint'(m_acc), 26);
        case (i_sm)
            2'd0, 2'd1: begin
                shv = (i_sm == 2'd0) ? (av >>> 2) : (av >>> 1);
                if (shv > 524287) shv = 524287;
                if (shv < -524288) shv = -524288;
            end
            2'd2: shv = sx(av >>> 1, 24);
            default: shv = sx(av, 24);
        endcase
        sh24 = shv[23:0];
        if (i_twe) m_tmp[7'(i_base + i_wr)] = sh24;
        if (i_fld) m_frac = (i_sm == 2'd3) ? sh24[23:11] : {1'b0, sh24[11:0]};
        if (i_ald) m_adr = (i_sm == 2'd3) ? {{4{sh24[23]}}, sh24[23:16]} : sh24[23:12];
        if (i_yld) m_y = i_in[23:4];
        m_acc = sv[25:0];
        e.acc = m_acc; e.frac = m_frac; e.adr = m_adr; e.yreg = m_y;
        e.vld = i_ewe; e.slot = i_slot; e.dat = sh24[19:4];
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares one scoreboard item per step, 1 ns after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(acc_out == e.acc, t, longint'(acc_out), longint'(e.acc));
                chk(frac_out == e.frac, "R10 frac", longint'(frac_out), longint'(e.frac));
                chk(addr_out == e.adr, "R11 addr", longint'(addr_out), longint'(e.adr));
                chk(yreg_out == e.yreg, "R12 yreg", longint'(yreg_out), longint'(e.yreg));
                chk(efx_vld == e.vld, "R8 strobe", longint'(efx_vld), longint'(e.vld));
                if (e.vld) begin
                    chk(efx_idx == e.slot, "R8 slot", longint'(efx_idx), longint'(e.slot));
                    chk(efx_data == e.dat, "R8 data", longint'(efx_data), longint'(e.dat));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) m_tmp[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        chk(acc_out == '0, "R1 acc", longint'(acc_out), 0);
        chk(frac_out == '0, "R1 frac", longint'(frac_out), 0);
        chk(addr_out == '0, "R1 addr", longint'(addr_out), 0);
        chk(yreg_out == '0, "R1 yreg", longint'(yreg_out), 0);
        chk(efx_vld == 1'b0, "R1 strobe", longint'(efx_vld), 0);
        // R1: ring entries read as zero (X from ring, large Y, B from ring)
        do_step("R1 ring", 24'h7FFFFF, 16'h7FF8, 7'd0, 1'b0, 7'd55, 2'd1, 1'b0, 1'b0, 1'b0,
                2'd3, 1'b0, 7'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        // R2/R4: X from bus, Y = coef top bits, Y register load
        do_step("R2 xbus", 24'h123456, 16'h4000, 7'd0, 1'b1, 7'd0, 2'd1, 1'b0, 1'b0, 1'b1,
                2'd3, 1'b0, 7'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1);
        // R7 mode 3 writeback of previous result into ring, frac, addr, effect
        do_step("R7 unity", 24'hFEDCBA, 16'hC008, 7'd10, 1'b1, 7'd0, 2'd2, 1'b0, 1'b0, 1'b1,
                2'd3, 1'b1, 7'd5, 1'b1, 4'd3, 1'b1, 1'b1, 1'b0);
        // R3: Y register low slice, R2 X from the ring entry just written
        do_step("R3 yzext", 24'h000000, 16'h0000, 7'd10, 1'b0, 7'd5, 2'd3, 1'b0, 1'b0, 1'b0,
                2'd2, 1'b1, 7'd6, 1'b1, 4'd9, 1'b1, 1'b0, 1'b0);
        // R3: Y from fraction register while reloading it
        do_step("R3 yfrac", 24'h3A5A5A, 16'h0000, 7'd10, 1'b1, 7'd0, 2'd0, 1'b1, 1'b1, 1'b0,
                2'd1, 1'b0, 7'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0);
        // R6: large positive result, then saturate in both clamping modes
        do_step("R6 load", 24'h7FFFFF, 16'h7FF8, 7'd0, 1'b1, 7'd0, 2'd1, 1'b0, 1'b0, 1'b1,
                2'd0, 1'b0, 7'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        do_step("R6 posdiv4", 24'h7FFFFF, 16'h7FF8, 7'd0, 1'b1, 7'd0, 2'd1, 1'b0, 1'b0, 1'b1,
                2'd0, 1'b1, 7'd20, 1'b1, 4'd15, 1'b1, 1'b1, 1'b0);
        do_step("R6 posdiv2", 24'h800000, 16'h7FF8, 7'd0, 1'b1, 7'd0, 2'd1, 1'b0, 1'b0, 1'b1,
                2'd1, 1'b0, 7'd0, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0);
        do_step("R6 negdiv2", 24'h000100, 16'h0008, 7'd0, 1'b1, 7'd0, 2'd1, 1'b0, 1'b0, 1'b1,
                2'd1, 1'b0, 7'd0, 1'b1, 4'd2, 1'b1, 1'b1, 1'b0);
        // R7: wrapping half scale of a large result
        do_step("R7 load", 24'h7FFFFF, 16'h7FF8, 7'd0, 1'b1, 7'd0, 2'd1, 1'b0, 1'b0, 1'b1,
                2'd2, 1'b0, 7'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        do_step("R7 wrap2", 24'h000000, 16'h0000, 7'd0, 1'b1, 7'd0, 2'd1, 1'b0, 1'b0, 1'b1,
                2'd2, 1'b1, 7'd100, 1'b1, 4'd4, 1'b1, 1'b1, 1'b0);
        // R5: B from previous result, subtracted; then B from ring times 4
        do_step("R5 accneg", 24'h012345, 16'h2000, 7'd0, 1'b1, 7'd0, 2'd1, 1'b1, 1'b1, 1'b0,
                2'd3, 1'b0, 7'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        do_step("R5 accadd", 24'h000000, 16'h0000, 7'd0, 1'b1, 7'd0, 2'd1, 1'b1, 1'b0, 1'b0,
                2'd3, 1'b0, 7'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        do_step("R5 tmpb", 24'h000010, 16'h0008, 7'd0, 1'b1, 7'd100, 2'd1, 1'b0, 1'b1, 1'b0,
                2'd3, 1'b0, 7'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        // R9: read and write of the same index in one step, base wrapping past 127
        do_step("R9 same", 24'h000000, 16'h4000, 7'd120, 1'b0, 7'd20, 2'd1, 1'b0, 1'b0, 1'b0,
                2'd3, 1'b1, 7'd20, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        do_step("R9 after", 24'h000000, 16'h4000, 7'd120, 1'b0, 7'd20, 2'd1, 1'b0, 1'b0, 1'b1,
                2'd3, 1'b0, 7'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        // R4: random steps across all fields
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r1, r2, r3;
            r1 = $urandom; r2 = $urandom; r3 = $urandom;
            do_step("R4 random", r1[23:0], r2[15:0], r3[6:0], r2[16], r3[13:7], r2[18:17],
                    r2[19], r2[20], r2[21] & r2[22], r2[24:23], r2[25], r3[20:14], r2[26],
                    r3[24:21], r2[27], r2[28], r2[29]);
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule